// File: doc/BRIEF.md
# Masked General-Purpose Pin Bank

This block manages a bank of eight pins. Each pin can be left as a plain input, used as a general-purpose I/O bit under register control, handed over to an alternate on-chip function, or taken over by a diagnostic test point. The block decides, for each pin, whether the pad driver is enabled and which value it drives. It also brings every pad input through a two-flop synchroniser before any register read can see it.

Software programs the bank through a small byte-wide register port. Two mode registers give each pin a 2-bit function code. A direction register, an output data register and a read mask register complete the set. A read-only level register returns the synchronised pin levels with the masked bits forced to zero. The same synchronised levels also leave the block unmasked on a separate vector, so an interrupt controller can watch every pin whether it is driving or receiving.

Top module: `pinbank_io`

## Requirements
- R1: After reset every register reads 0, every `pad_oe` bit is 0 and every `pad_out` bit is 0.
- R2: A pin whose function code is 00 (off) or 11 (reserved) has `pad_oe` = 0 and `pad_out` = 0, unless its test-point enable is set.
- R3: A pin whose function code is 01 (GPIO) has `pad_oe` equal to its direction bit (1 = output). It drives its data register bit when that direction bit is 1 and drives 0 when it is 0.
- R4: A pin whose function code is 10 (alternate) has `pad_oe` = 1 and drives its `alt_val` bit.
- R5: When `tp_en[i]` is 1, pin i has `pad_oe` = 1 and drives `tp_sig[i]`, whatever its function code and direction bit.
- R6: A value on `pad_in` appears on `pin_level` after exactly two rising clock edges.
- R7: A read at address 5 returns `pin_level` with every bit whose read mask bit is 1 forced to 0.
- R8: Addresses 0 to 4 read back the last byte written there. Address 0 holds the function codes of pins 3..0 and address 1 those of pins 7..4, with pin i (mod 4) at bits [2i+1:2i]. Address 2 is direction, 3 is output data and 4 is read mask.
- R9: Writes to addresses 5, 6 and 7 change no register. Addresses 6 and 7 read 0.
- R10: `pin_level` carries the synchronised level of every pin, whatever its direction, function code or mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| tp_en | input | 8 | Per-pin diagnostic test-point enable |
| tp_sig | input | 8 | Test-point values, one per pin |
| alt_val | input | 8 | Alternate-function output values, one per pin |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| pin_level | output | 8 | Synchronised pin levels, unmasked |

## Verification
On every cycle, the assertions check four things: test-point override of the pad driver, that no undriven pin carries a nonzero output, the two-edge synchroniser delay, and that a level read never shows a bit the synchronised level lacks. Only the bench scenarios can show the rest. These are the exact per-code selection between off, GPIO and alternate, register readback and the address map, the ignoring of writes to read-only and unused addresses, and the mask taking away exactly the chosen bits.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  typedef enum logic [1:0] {
    FN_OFF  = 2'b00,
    FN_GPIO = 2'b01,
    FN_ALT  = 2'b10,
    FN_RSV  = 2'b11
  } pin_fn_e;

  localparam int unsigned FN_W = 2;

endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] async_in,
  output logic [DW-1:0] sync_out
);

  logic [DW-1:0] stage_q [STAGES];
  logic [DW-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          stage_q[s] <= stage_d[s];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW-1:0]      level_in,
  output logic [DW*FN_W-1:0] fn_cfg,
  output logic [DW-1:0]      dir_cfg,
  output logic [DW-1:0]      data_cfg,
  output logic [DW-1:0]      mask_cfg,
  output logic [DW-1:0]      rd_data
);

  localparam int unsigned FN_REGS    = (DW * FN_W) / DW;
  localparam int unsigned ADDR_DIR   = FN_REGS;
  localparam int unsigned ADDR_DATA  = FN_REGS + 1;
  localparam int unsigned ADDR_MASK  = FN_REGS + 2;
  localparam int unsigned ADDR_LEVEL = FN_REGS + 3;

  logic [DW*FN_W-1:0] fn_q,   fn_d;
  logic [DW-1:0]      dir_q,  dir_d;
  logic [DW-1:0]      data_q, data_d;
  logic [DW-1:0]      mask_q, mask_d;

  logic hit_dir, hit_data, hit_mask;

  assign hit_dir  = wr_en && (addr == AW'(ADDR_DIR));
  assign hit_data = wr_en && (addr == AW'(ADDR_DATA));
  assign hit_mask = wr_en && (addr == AW'(ADDR_MASK));

  always_comb begin
    fn_d = fn_q;
    for (int r = 0; r < FN_REGS; r++) begin
      if (wr_en && (addr == AW'(r))) begin
        fn_d[r*DW +: DW] = wr_data;
      end
    end
  end

  always_comb begin
    dir_d  = hit_dir  ? wr_data : dir_q;
    data_d = hit_data ? wr_data : data_q;
    mask_d = hit_mask ? wr_data : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q   <= '0;
      dir_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      fn_q   <= fn_d;
      dir_q  <= dir_d;
      data_q <= data_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < FN_REGS; r++) begin
      if (addr == AW'(r)) begin
        rd_data = fn_q[r*DW +: DW];
      end
    end
    if (addr == AW'(ADDR_DIR))   rd_data = dir_q;
    if (addr == AW'(ADDR_DATA))  rd_data = data_q;
    if (addr == AW'(ADDR_MASK))  rd_data = mask_q;
    if (addr == AW'(ADDR_LEVEL)) rd_data = level_in & ~mask_q;
  end

  assign fn_cfg   = fn_q;
  assign dir_cfg  = dir_q;
  assign data_cfg = data_q;
  assign mask_cfg = mask_q;

endmodule

// File: rtl/pinbank_pinmux.sv
module pinbank_pinmux
  import pinbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW*FN_W-1:0] fn_cfg,
  input  logic [DW-1:0]      dir_cfg,
  input  logic [DW-1:0]      data_cfg,
  input  logic [DW-1:0]      tp_en,
  input  logic [DW-1:0]      tp_sig,
  input  logic [DW-1:0]      alt_val,
  output logic [DW-1:0]      pad_out,
  output logic [DW-1:0]      pad_oe
);

  generate
    for (genvar i = 0; i < DW; i++) begin : g_pin
      pin_fn_e fn;
      assign fn = pin_fn_e'(fn_cfg[i*FN_W +: FN_W]);

      always_comb begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
        if (tp_en[i]) begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = tp_sig[i];
        end else begin
          unique case (fn)
            FN_GPIO: begin
              pad_oe[i]  = dir_cfg[i];
              pad_out[i] = dir_cfg[i] & data_cfg[i];
            end
            FN_ALT: begin
              pad_oe[i]  = 1'b1;
              pad_out[i] = alt_val[i];
            end
            default: begin
              pad_oe[i]  = 1'b0;
              pad_out[i] = 1'b0;
            end
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pinbank_io.sv
module pinbank_io
  import pinbank_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] tp_en,
  input  logic [DW-1:0] tp_sig,
  input  logic [DW-1:0] alt_val,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  output logic [DW-1:0] pin_level
);

  logic               rst_n_int;
  logic [DW*FN_W-1:0] fn_cfg;
  logic [DW-1:0]      dir_cfg;
  logic [DW-1:0]      data_cfg;
  logic [DW-1:0]      mask_cfg;
  logic [DW-1:0]      level_sync;

  pinbank_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pinbank_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (pad_in),
    .sync_out (level_sync)
  );

  pinbank_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .level_in (level_sync),
    .fn_cfg   (fn_cfg),
    .dir_cfg  (dir_cfg),
    .data_cfg (data_cfg),
    .mask_cfg (mask_cfg),
    .rd_data  (rd_data)
  );

  pinbank_pinmux #(.DW(DW)) u_mux (
    .fn_cfg   (fn_cfg),
    .dir_cfg  (dir_cfg),
    .data_cfg (data_cfg),
    .tp_en    (tp_en),
    .tp_sig   (tp_sig),
    .alt_val  (alt_val),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign pin_level = level_sync;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n_int,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] tp_en,
  input logic [DW-1:0] tp_sig,
  input logic [DW-1:0] pad_in,
  input logic [DW-1:0] pad_out,
  input logic [DW-1:0] pad_oe,
  input logic [DW-1:0] pin_level
);

  localparam logic [AW-1:0] LEVEL_ADDR = AW'(5);

  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      up_cnt <= 2'd0;
    end else if (up_cnt != 2'd3) begin
      up_cnt <= up_cnt + 2'd1;
    end
  end

  p_tp_drive_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((pad_oe & tp_en) == tp_en) && (((pad_out ^ tp_sig) & tp_en) == '0));

  p_quiet_undriven_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pad_out & ~pad_oe) == '0);

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (up_cnt == 2'd3) |-> (pin_level == $past(pad_in, 2)));

  p_read_subset_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (addr == LEVEL_ADDR) |-> ((rd_data & ~pin_level) == '0));

endmodule

bind pinbank_io pinbank_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .addr      (addr),
  .rd_data   (rd_data),
  .tp_en     (tp_en),
  .tp_sig    (tp_sig),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pin_level (pin_level)
);

// File: tb/sim_pinbank_io.sv
`timescale 1ns/1ps
module sim_pinbank_io;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [7:0] tp_en, tp_sig, alt_val, pad_in;
  logic [7:0] pad_out, pad_oe, pin_level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] sh_fn;
  logic [7:0]  sh_dir, sh_data, sh_mask;

  always #4 clk = ~clk;

  pinbank_io u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tp_en(tp_en), .tp_sig(tp_sig), .alt_val(alt_val),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_level(pin_level)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_oe(logic [15:0] fn, logic [7:0] dir, logic [7:0] tpe);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (tpe[i])                   r[i] = 1'b1;
      else if (fn[2*i +: 2] == 2'b01) r[i] = dir[i];
      else if (fn[2*i +: 2] == 2'b10) r[i] = 1'b1;
      else                          r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_out(logic [15:0] fn, logic [7:0] dir, logic [7:0] dat,
                                         logic [7:0] tpe, logic [7:0] tps, logic [7:0] alt);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (tpe[i])                   r[i] = tps[i];
      else if (fn[2*i +: 2] == 2'b01) r[i] = dir[i] & dat[i];
      else if (fn[2*i +: 2] == 2'b10) r[i] = alt[i];
      else                          r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: sh_fn[7:0]  = d;
      3'd1: sh_fn[15:8] = d;
      3'd2: sh_dir      = d;
      3'd3: sh_data     = d;
      3'd4: sh_mask     = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(string req, logic [2:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic pins_check(string req);
    #1;
    check({req, " oe"},  pad_oe,  exp_oe(sh_fn, sh_dir, tp_en));
    check({req, " out"}, pad_out, exp_out(sh_fn, sh_dir, sh_data, tp_en, tp_sig, alt_val));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    tp_en = '0; tp_sig = '0; alt_val = 8'hFF; pad_in = 8'hA5;
    sh_fn = '0; sh_dir = '0; sh_data = '0; sh_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state (inputs still propagating through synchroniser)
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    for (int a = 0; a < 5; a++) rd_check("R1 reg", 3'(a), 8'h00);

    // R6 exact two-edge delay
    repeat (2) @(negedge clk);
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); #1 check("R6 one edge", pin_level, 8'hA5);
    @(negedge clk); #1 check("R6 two edges", pin_level, 8'h3C);
    check("R10 level", pin_level, 8'h3C);
    rd_check("R7 unmasked", 3'd5, 8'h3C);

    // R8 readback and map
    wr(3'd0, 8'h1B); wr(3'd1, 8'hE4); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3); wr(3'd4, 8'h0F);
    rd_check("R8 fn lo", 3'd0, 8'h1B);
    rd_check("R8 fn hi", 3'd1, 8'hE4);
    rd_check("R8 dir", 3'd2, 8'h5A);
    rd_check("R8 data", 3'd3, 8'hC3);
    rd_check("R8 mask", 3'd4, 8'h0F);
    rd_check("R7 masked", 3'd5, 8'h30);

    // R9 writes to read-only/unused addresses ignored
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd_check("R9 addr6", 3'd6, 8'h00);
    rd_check("R9 addr7", 3'd7, 8'h00);
    for (int a = 0; a < 5; a++) begin
      logic [7:0] e;
      e = (a == 0) ? sh_fn[7:0] : (a == 1) ? sh_fn[15:8] : (a == 2) ? sh_dir :
          (a == 3) ? sh_data : sh_mask;
      rd_check("R9 regs kept", 3'(a), e);
    end
    pins_check("R9 pins kept");

    // R2 all off / reserved
    wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    pins_check("R2 off+rsv");
    // R3 all GPIO
    wr(3'd0, 8'h55); wr(3'd1, 8'h55); wr(3'd2, 8'hF0); wr(3'd3, 8'hAA);
    pins_check("R3 gpio");
    // R4 all alternate
    wr(3'd0, 8'hAA); wr(3'd1, 8'hAA); alt_val = 8'h96;
    pins_check("R4 alt");
    // R5 test point overrides everything
    tp_en = 8'hFF; tp_sig = 8'h5C;
    pins_check("R5 tp all");
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    pins_check("R5 tp over off");
    tp_en = 8'h00;

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      a = $urandom_range(0, 7);
      wr(3'(a), 8'($urandom));
      tp_en = 8'($urandom) & 8'($urandom); tp_sig = 8'($urandom); alt_val = 8'($urandom);
      pins_check("R2 R3 R4 R5 random");
      if ((n % 8) == 0) begin
        logic [7:0] v;
        v = 8'($urandom);
        @(negedge clk); pad_in = v;
        @(negedge clk); @(negedge clk);
        #1 check("R6 R10 random level", pin_level, v);
        rd_check("R7 random read", 3'd5, v & ~sh_mask);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule